// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the integer execute stage of a small processor core. In one cycle it applies one of fourteen operations to two operands: four carry-aware additions and subtractions, four bitwise logic functions, two pass-through moves and four compare/test functions. It holds a four-bit condition store with the fields negative, zero, carry and overflow. The result is combinational, so a surrounding pipeline can write it back in the same cycle, qualified by a write-enable. The condition store updates on the clock edge of an accepted operation.

Compare/test operations exist only to update the condition store, so they never request a write-back. Other operations touch the store only when the caller sets the flag-update request. The two carry-consuming operations read the stored carry, which lets a sequence of word-wide operations form wider arithmetic. The operand width is a parameter and defaults to 32 bits.

Top module: `flag_alu`

## Requirements
- R1: Arithmetic results follow the operation code. 0 gives A+B, 1 gives A+B+C, 2 gives A-B, and 3 gives A-B+C-1, where C is the stored carry flag. All are taken modulo 2^DATA_W.
- R2: Bitwise results follow the operation code. 4 gives A AND B, 5 gives A OR B, 6 gives A XOR B, 7 gives A AND NOT B, 8 gives B, and 9 gives NOT B.
- R3: `result_we` equals `op_valid` for codes 0 to 9. It is always 0 for codes 10 to 15.
- R4: The flags change only on a clock edge where `op_valid` is 1 and either the code is 10 to 13, or the code is 0 to 9 with `set_flags` at 1. At all other edges they hold.
- R5: `flags` is {N,Z,C,V} with N in bit 3 and V in bit 0. On an update, N takes the MSB of the computed value and Z is 1 exactly when that value is zero. Code 10 computes A-B, 11 computes A+B, 12 computes A AND B, and 13 computes A XOR B.
- R6: On an update by codes 0, 1 and 11, C is the carry out of the MSB. For codes 2, 3 and 10, C is 1 when no borrow occurs, that is, when A+~B+cin carries out.
- R7: On an arithmetic update, V is 1 exactly when the signed result lies outside the DATA_W-bit two's-complement range. This means the addend signs match and the result sign differs.
- R8: Codes 4 to 9, 12 and 13 leave C and V unchanged even when they update N and Z.
- R9: Codes 14 and 15 neither assert `result_we` nor change the flags.
- R10: When `rst_n` goes low, the flags become 0000 at once, without waiting for a clock edge.
- R11: A flag update is visible from the following cycle. An add with flag update on the low words, followed by code 1 on the high words, gives the exact double-width sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Flag-update request for codes 0 to 9 |
| opnd_a | input | DATA_W | First operand |
| opnd_b | input | DATA_W | Second operand |
| result | output | DATA_W | Combinational result (zero for codes 10 to 15) |
| result_we | output | 1 | Result write-enable |
| flags | output | 4 | Stored {N,Z,C,V} |

## Verification
`result` and `result_we` are due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples them one time unit later, before the next rising edge. The flags are due one register later. They are sampled one time unit after the rising edge that accepted the operation, and they are compared with a bench-side flag model updated at that same edge. The carry seen by each carry-consuming operation therefore comes from the bench's own model. The bench also confirms that reset clears the flags between clock edges.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_SUB    = 4'd2,
    OP_SUBC   = 4'd3,
    OP_AND    = 4'd4,
    OP_OR     = 4'd5,
    OP_XOR    = 4'd6,
    OP_ANDN   = 4'd7,
    OP_PASS   = 4'd8,
    OP_PASSN  = 4'd9,
    OP_CMPSUB = 4'd10,
    OP_CMPADD = 4'd11,
    OP_TSTAND = 4'd12,
    OP_TSTXOR = 4'd13,
    OP_NOP14  = 4'd14,
    OP_NOP15  = 4'd15
  } dp_op_e;

  typedef enum logic [2:0] {
    LF_AND   = 3'd0,
    LF_OR    = 3'd1,
    LF_XOR   = 3'd2,
    LF_ANDN  = 3'd3,
    LF_PASS  = 3'd4,
    LF_PASSN = 3'd5
  } logic_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  assign b_eff = invert_b ? ~b : b;
  assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = wide[W-1:0];
  assign cout  = wide[W];
  assign ovf   = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import dpalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] y
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (fn)
        LF_AND:   y[i] = a[i] & b[i];
        LF_OR:    y[i] = a[i] | b[i];
        LF_XOR:   y[i] = a[i] ^ b[i];
        LF_ANDN:  y[i] = a[i] & ~b[i];
        LF_PASS:  y[i] = b[i];
        LF_PASSN: y[i] = ~b[i];
        default:  y[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
  import dpalu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  nzcv_t d,
  output nzcv_t q
);

  nzcv_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> q == $past(q)); // R4

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import dpalu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [3:0]        flags
);

  localparam int MSB = DATA_W - 1;

  dp_op_e            op;
  nzcv_t             cur, nxt;
  logic              is_arith, invert_b, cin, writes, is_cmp, upd;
  logic_fn_e         lfn;
  logic [DATA_W-1:0] sum, lval, value;
  logic              cout, ovf;

  assign op = dp_op_e'(op_code);

  always_comb begin
    is_arith = 1'b0;
    invert_b = 1'b0;
    cin      = 1'b0;
    lfn      = LF_AND;
    writes   = 1'b0;
    is_cmp   = 1'b0;
    unique case (op)
      OP_ADD:    begin is_arith = 1'b1; writes = 1'b1; end
      OP_ADDC:   begin is_arith = 1'b1; writes = 1'b1; cin = cur.c; end
      OP_SUB:    begin is_arith = 1'b1; writes = 1'b1; invert_b = 1'b1; cin = 1'b1; end
      OP_SUBC:   begin is_arith = 1'b1; writes = 1'b1; invert_b = 1'b1; cin = cur.c; end
      OP_AND:    begin writes = 1'b1; lfn = LF_AND; end
      OP_OR:     begin writes = 1'b1; lfn = LF_OR; end
      OP_XOR:    begin writes = 1'b1; lfn = LF_XOR; end
      OP_ANDN:   begin writes = 1'b1; lfn = LF_ANDN; end
      OP_PASS:   begin writes = 1'b1; lfn = LF_PASS; end
      OP_PASSN:  begin writes = 1'b1; lfn = LF_PASSN; end
      OP_CMPSUB: begin is_arith = 1'b1; is_cmp = 1'b1; invert_b = 1'b1; cin = 1'b1; end
      OP_CMPADD: begin is_arith = 1'b1; is_cmp = 1'b1; end
      OP_TSTAND: begin is_cmp = 1'b1; lfn = LF_AND; end
      OP_TSTXOR: begin is_cmp = 1'b1; lfn = LF_XOR; end
      default:   begin end
    endcase
  end

  flag_alu_adder #(.W(DATA_W)) i_adder (
    .a        (opnd_a),
    .b        (opnd_b),
    .invert_b (invert_b),
    .cin      (cin),
    .sum      (sum),
    .cout     (cout),
    .ovf      (ovf)
  );

  flag_alu_logic #(.W(DATA_W)) i_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .fn (lfn),
    .y  (lval)
  );

  assign value     = is_arith ? sum : lval;
  assign result    = writes ? value : '0;
  assign result_we = op_valid & writes;
  assign upd       = op_valid & (is_cmp | (writes & set_flags));

  always_comb begin
    nxt.n = value[MSB];
    nxt.z = (value == '0);
    nxt.c = is_arith ? cout : cur.c;
    nxt.v = is_arith ? ovf  : cur.v;
  end

  flag_alu_flags i_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (upd),
    .d     (nxt),
    .q     (cur)
  );

  assign flags = cur;

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code inside {[4'd10:4'd13]} |-> !result_we); // R3

  AST_IDLE_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags)); // R4

  AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    result_we && set_flags |=> flags[3] == $past(result[MSB])); // R5

  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    result_we && set_flags |=> flags[2] == ($past(result) == '0)); // R5

  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code inside {[4'd4:4'd9], 4'd12, 4'd13} |=>
      flags[1:0] == $past(flags[1:0])); // R8

  AST_SPARE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code inside {4'd14, 4'd15} |-> !result_we); // R9

  AST_SPARE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code inside {4'd14, 4'd15} |=> $stable(flags)); // R9

endmodule

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;

  localparam int    W    = 8;
  localparam int    MASK = (1 << W) - 1;
  localparam int    HALF = 1 << (W - 1);
  localparam real   TCLK = 5.0;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid;
  logic [3:0]   op_code;
  logic         set_flags;
  logic [W-1:0] opnd_a, opnd_b;
  logic [W-1:0] result;
  logic         result_we;
  logic [3:0]   flags;

  int checks = 0;
  int errors = 0;
  int exp_n = 0, exp_z = 0, exp_c = 0, exp_v = 0;
  int last_res = 0;

  always #(TCLK / 2) clk = ~clk;

  flag_alu #(.DATA_W(W)) i_flag_alu (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .set_flags (set_flags),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .result_we (result_we),
    .flags     (flags)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sgn(input int x);
    return (x >= HALF) ? x - (1 << W) : x;
  endfunction

  function automatic int eflags();
    return (exp_n << 3) | (exp_z << 2) | (exp_c << 1) | exp_v;
  endfunction

  task automatic do_op(input int op, input int a, input int b, input bit sf, input bit vld);
    int res, cy, ov, ex, cin;
    bit arith, we, upd;
    @(negedge clk);
    op_valid = vld; op_code = op[3:0]; set_flags = sf;
    opnd_a = a[W-1:0]; opnd_b = b[W-1:0];
    arith = 0; cy = exp_c; ov = exp_v; res = 0;
    cin = (op == 0 || op == 11) ? 0 : (op == 2 || op == 10) ? 1 : exp_c;
    case (op)
      0, 1, 11: begin
        arith = 1; ex = a + b + cin; res = ex & MASK; cy = (ex > MASK) ? 1 : 0;
        ex = sgn(a) + sgn(b) + cin;
        ov = (ex >= HALF || ex < -HALF) ? 1 : 0;
      end
      2, 3, 10: begin
        arith = 1; res = (a - b - 1 + cin) & MASK; cy = (a + cin > b) ? 1 : 0;
        ex = sgn(a) - sgn(b) - 1 + cin;
        ov = (ex >= HALF || ex < -HALF) ? 1 : 0;
      end
      4, 12: res = a & b;
      5:     res = a | b;
      6, 13: res = a ^ b;
      7:     res = a & ~b & MASK;
      8:     res = b;
      9:     res = ~b & MASK;
      default: res = 0;
    endcase
    we  = vld && op <= 9;
    upd = vld && ((op >= 10 && op <= 13) || (sf && op <= 9));
    #1;
    check("R3 write-enable", int'(result_we), int'(we));
    if (we) check(arith ? "R1 arithmetic result" : "R2 bitwise result", int'(result), res);
    last_res = int'(result);
    if (upd) begin
      exp_n = (res >> (W - 1)) & 1;
      exp_z = (res == 0) ? 1 : 0;
      exp_c = cy;
      exp_v = ov;
    end
    @(posedge clk); #1;
    if (!upd)       check(op >= 14 ? "R9 spare code flags" : "R4 flag hold", int'(flags), eflags());
    else if (arith) check("R5,R6,R7 arithmetic flags", int'(flags), eflags());
    else            check("R5,R8 logic flags", int'(flags), eflags());
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals[16] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h3C, 8'h55, 8'h7E,
                     8'h7F, 8'h80, 8'h81, 8'hAA, 8'hC3, 8'hF0, 8'hFE, 8'hFF};
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; set_flags = 1'b0;
    opnd_a = '0; opnd_b = '0;
    repeat (3) @(posedge clk);
    #1 check("R10 reset flags", int'(flags), 0);
    @(negedge clk) rst_n = 1'b1;

    // R10: async clear between edges
    do_op(0, 8'h80, 8'h80, 1, 1);   // C=1, V=1, Z=1
    #1 rst_n = 1'b0;
    #0.5 check("R10 async clear", int'(flags), 0);
    exp_n = 0; exp_z = 0; exp_c = 0; exp_v = 0;
    @(negedge clk) rst_n = 1'b1;

    // R4: idle cycle with a flag-setting add presented
    do_op(0, 8'h7F, 8'h01, 1, 1);
    do_op(0, 8'hFF, 8'h01, 1, 0);
    check("R4 idle keeps flags", int'(flags), eflags());

    // R1..R9 sweep over all codes, operand set, carry-in and set_flags
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 16; ia++)
        for (int ib = 0; ib < 16; ib++)
          for (int c = 0; c < 2; c++) begin
            do_op(0, c ? 8'hFF : 8'h00, c ? 8'h01 : 8'h00, 1, 1);
            do_op(op, vals[ia], vals[ib], ((ia + ib + c) % 2) == 0, 1);
          end

    // R11: double-width add through the stored carry
    for (int k = 0; k < 24; k++) begin
      int x, y, lo, hi;
      x = (k * 40503 + 12345) & 16'hFFFF;
      y = (k * 9973 + 777 + k * k * 131) & 16'hFFFF;
      do_op(0, x & MASK, y & MASK, 1, 1);
      lo = last_res;
      do_op(1, x >> W, y >> W, 1, 1);
      hi = last_res;
      check("R11 wide sum", (hi << W) | lo, (x + y) & 16'hFFFF);
      check("R11 wide carry", int'(flags[1]), (x + y) >> 16);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule